// File: doc/BRIEF.md
# Dual-Clock Fall-Through FIFO

This block moves 18-bit words from one clock domain to another through a 1024-entry array. The write and read clocks run freely and have no fixed relation. Behind the array sits a registered output stage. That stage holds one more word, so the block stores 1025 words in total. When a word is written into an empty FIFO, it moves into the output stage by itself, with no read request. The consumer sees the word as soon as the output-ready flag rises, and it acknowledges the word by reading it.

The two domains exchange their positions as Gray-coded pointers. Each pointer passes through a two-flop synchronizer in the receiving domain, which fixes the flag latencies in clock edges. The write domain also exports an occupancy count that covers both the array and the output stage. A separate threshold-flag block uses this count. A single active-low reset serves both domains, and each domain has its own synchronizer for it.

Top module: `xff_top`

## Requirements
- R1: A word is stored at a rising `wr_clk` edge only when `wr_en_a`, `wr_en_b` and `wr_rdy` are all high before that edge. With only one enable high, the word is dropped and `wr_level` stays unchanged.
- R2: Once a word is shown at the output, it is consumed at a rising `rd_clk` edge only when `rd_en_a`, `rd_en_b`, `rd_oe` and `rd_rdy` are all high. Otherwise `rd_data` and `rd_rdy` hold.
- R3: A word written into an empty FIFO appears on `rd_data` at the third rising `rd_clk` edge after the write edge, with both read enables low. `rd_rdy` rises at that same edge and is still low after the second edge.
- R4: `rd_rdy` falls at the `rd_clk` edge that consumes the last stored word.
- R5: The FIFO holds 1025 words. `wr_rdy` is still high before the 1025th write and goes low at that write's edge. Writes attempted while it is low are dropped.
- R6: After the FIFO is full, `wr_rdy` returns high at the second `wr_clk` edge after the read edge that frees a slot, and it is still low after the first.
- R7: After `rst_n` falls, `wr_rdy` goes low at the second `wr_clk` edge and `rd_rdy` goes low at the third `rd_clk` edge. After release, `wr_rdy` rises at the second `wr_clk` edge, and the FIFO is empty with `wr_level` equal to 0.
- R8: `rd_vld` is high exactly when `rd_oe` and `rd_rdy` are both high. With `rd_oe` low, no word is consumed.
- R9: `wr_level` equals the words accepted minus the words consumed, within 0 to 1025. Writes show at their own edge, and reads show two `wr_clk` edges later.
- R10: Words leave in the order they were accepted, with their values unchanged. The pointers crossing the domains change by at most one bit per edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_en_a | input | 1 | First write enable, active high |
| wr_en_b | input | 1 | Second write enable, active high |
| wr_data | input | 18 | Word to store |
| wr_rdy | output | 1 | Space available (input ready) |
| wr_level | output | 11 | Stored words seen from the write domain, 0 to 1025 |
| rd_clk | input | 1 | Read-domain clock |
| rd_en_a | input | 1 | First read enable, active high |
| rd_en_b | input | 1 | Second read enable, active high |
| rd_oe | input | 1 | Output enable |
| rd_data | output | 18 | Output-stage word |
| rd_rdy | output | 1 | Output stage holds a word (output ready) |
| rd_vld | output | 1 | Output word valid for the consumer (ready and enabled) |
| rst_n | input | 1 | Reset for both domains, active low |

## Verification
The assertions assume that `rst_n` stays low for at least four edges of each clock. They also assume that inputs do not change at the clock edge that samples them. The bench runs two clocks whose rising edges never coincide, and it changes inputs two time units after an edge. It holds reset for six edges of each clock at start-up and again in the middle of the run. As a result, every synchronizer settles to a defined value before any flag is judged.

// File: rtl/xff_pkg.sv
package xff_pkg;

  // Binary to reflected Gray code; callers slice the low bits they need.
  function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // Gray back to binary, most significant bit first.
  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // Modular distance between a leading and a trailing pointer.
  function automatic logic [31:0] ptr_gap(input logic [31:0] lead, input logic [31:0] lag);
    return lead - lag;
  endfunction

endpackage

// File: rtl/xff_rst_sync.sv
module xff_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk) shreg <= {shreg[STAGES-2:0], arst_n};

  assign rst = !shreg[STAGES-1];
endmodule

// File: rtl/xff_gray_sync.sv
module xff_gray_sync #(
  parameter int W      = 11,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_gray,
  output logic [W-1:0] q_gray
);
  logic [W-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst)         stage[g] <= '0;
      else if (g == 0) stage[g] <= d_gray;
      else             stage[g] <= stage[(g == 0) ? 0 : g-1];
    end
  end

  assign q_gray = stage[STAGES-1];
endmodule

// File: rtl/xff_wr_side.sv
module xff_wr_side #(
  parameter int ADDR_W = 10,
  parameter int SYNC_N = 2,
  localparam int PTR_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_a,
  input  logic              en_b,
  input  logic [PTR_W-1:0]  pop_gray,   // array pops, read domain
  input  logic [PTR_W-1:0]  take_gray,  // consumer reads, read domain
  output logic              fire,
  output logic [ADDR_W-1:0] addr,
  output logic [PTR_W-1:0]  push_gray,
  output logic              ready,
  output logic [PTR_W-1:0]  level
);
  localparam logic [PTR_W-1:0] ARRAY_WORDS = PTR_W'(1 << ADDR_W);

  logic [PTR_W-1:0] wptr, wptr_n;
  logic [PTR_W-1:0] pop_gray_s, take_gray_s, pop_bin_s, take_bin_s;
  logic [PTR_W-1:0] array_used;

  xff_gray_sync #(.W(PTR_W), .STAGES(SYNC_N)) u_pop_sync (
    .clk(clk), .rst(rst), .d_gray(pop_gray), .q_gray(pop_gray_s));
  xff_gray_sync #(.W(PTR_W), .STAGES(SYNC_N)) u_take_sync (
    .clk(clk), .rst(rst), .d_gray(take_gray), .q_gray(take_gray_s));

  assign pop_bin_s  = PTR_W'(xff_pkg::gray_to_bin(32'(pop_gray_s)));
  assign take_bin_s = PTR_W'(xff_pkg::gray_to_bin(32'(take_gray_s)));
  assign array_used = PTR_W'(xff_pkg::ptr_gap(32'(wptr), 32'(pop_bin_s)));

  assign ready  = !rst && (array_used != ARRAY_WORDS);
  assign fire   = en_a && en_b && ready;
  assign wptr_n = wptr + PTR_W'(1);
  assign addr   = wptr[ADDR_W-1:0];
  assign level  = PTR_W'(xff_pkg::ptr_gap(32'(wptr), 32'(take_bin_s)));

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr      <= '0;
      push_gray <= '0;
    end else if (fire) begin
      wptr      <= wptr_n;
      push_gray <= PTR_W'(xff_pkg::bin_to_gray(32'(wptr_n)));
    end
  end
endmodule

// File: rtl/xff_rd_side.sv
module xff_rd_side #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18,
  parameter int SYNC_N = 2,
  localparam int PTR_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_a,
  input  logic              en_b,
  input  logic              oe,
  input  logic [PTR_W-1:0]  push_gray,  // write domain
  input  logic [DATA_W-1:0] mem_q,
  output logic [ADDR_W-1:0] addr,
  output logic              load,
  output logic              take,
  output logic [PTR_W-1:0]  pop_gray,
  output logic [PTR_W-1:0]  take_gray,
  output logic              hold_full,
  output logic [DATA_W-1:0] hold_data
);
  logic [PTR_W-1:0] rptr, rptr_n, cptr, cptr_n;
  logic [PTR_W-1:0] push_gray_s, push_bin_s;
  logic             array_empty;

  xff_gray_sync #(.W(PTR_W), .STAGES(SYNC_N)) u_push_sync (
    .clk(clk), .rst(rst), .d_gray(push_gray), .q_gray(push_gray_s));

  assign push_bin_s  = PTR_W'(xff_pkg::gray_to_bin(32'(push_gray_s)));
  assign array_empty = (rptr == push_bin_s);
  assign take        = en_a && en_b && oe && hold_full;
  assign load        = !array_empty && (!hold_full || take);
  assign rptr_n      = rptr + PTR_W'(1);
  assign cptr_n      = cptr + PTR_W'(1);
  assign addr        = rptr[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rptr      <= '0;
      cptr      <= '0;
      pop_gray  <= '0;
      take_gray <= '0;
      hold_full <= 1'b0;
    end else begin
      hold_full <= load || (hold_full && !take);
      if (load) begin
        rptr     <= rptr_n;
        pop_gray <= PTR_W'(xff_pkg::bin_to_gray(32'(rptr_n)));
      end
      if (take) begin
        cptr      <= cptr_n;
        take_gray <= PTR_W'(xff_pkg::bin_to_gray(32'(cptr_n)));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (load) hold_data <= mem_q;
  end
endmodule

// File: rtl/xff_top.sv
module xff_top #(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 10,
  parameter int SYNC_N = 2,
  localparam int PTR_W = ADDR_W + 1,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              wr_clk,
  input  logic              wr_en_a,
  input  logic              wr_en_b,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_rdy,
  output logic [PTR_W-1:0]  wr_level,
  input  logic              rd_clk,
  input  logic              rd_en_a,
  input  logic              rd_en_b,
  input  logic              rd_oe,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_rdy,
  output logic              rd_vld,
  input  logic              rst_n
);
  // Named internal events, observed by the bound checker.
  logic              w_rst, r_rst;
  logic              w_fire, r_load, r_take;
  logic [ADDR_W-1:0] w_addr, r_addr;
  logic [PTR_W-1:0]  w_gray, r_pop_gray, r_take_gray;
  logic [DATA_W-1:0] r_mem_q;
  logic [DATA_W-1:0] mem [DEPTH];

  xff_rst_sync #(.STAGES(SYNC_N)) u_wrst (.clk(wr_clk), .arst_n(rst_n), .rst(w_rst));
  xff_rst_sync #(.STAGES(SYNC_N)) u_rrst (.clk(rd_clk), .arst_n(rst_n), .rst(r_rst));

  xff_wr_side #(.ADDR_W(ADDR_W), .SYNC_N(SYNC_N)) u_wr (
    .clk(wr_clk), .rst(w_rst), .en_a(wr_en_a), .en_b(wr_en_b),
    .pop_gray(r_pop_gray), .take_gray(r_take_gray),
    .fire(w_fire), .addr(w_addr), .push_gray(w_gray),
    .ready(wr_rdy), .level(wr_level));

  always_ff @(posedge wr_clk) begin
    if (w_fire) mem[w_addr] <= wr_data;
  end

  assign r_mem_q = mem[r_addr];

  xff_rd_side #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_N(SYNC_N)) u_rd (
    .clk(rd_clk), .rst(r_rst), .en_a(rd_en_a), .en_b(rd_en_b), .oe(rd_oe),
    .push_gray(w_gray), .mem_q(r_mem_q), .addr(r_addr),
    .load(r_load), .take(r_take), .pop_gray(r_pop_gray), .take_gray(r_take_gray),
    .hold_full(rd_rdy), .hold_data(rd_data));

  assign rd_vld = rd_rdy && rd_oe;
endmodule

// File: rtl/xff_checks.sv
module xff_checks #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18,
  localparam int PTR_W = ADDR_W + 1
) (
  input logic              wr_clk,
  input logic              rd_clk,
  input logic              w_rst,
  input logic              r_rst,
  input logic              wr_rdy,
  input logic [PTR_W-1:0]  wr_level,
  input logic [PTR_W-1:0]  w_gray,
  input logic [PTR_W-1:0]  r_pop_gray,
  input logic              rd_rdy,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_en_a,
  input logic              rd_en_b,
  input logic              rd_oe,
  input logic              r_load,
  input logic              r_take
);
  localparam logic [PTR_W-1:0] CAP = PTR_W'((1 << ADDR_W) + 1);

  // R5: no push while the ready flag is low
  p_no_push_when_full_r5: assert property (@(posedge wr_clk) disable iff (w_rst)
    !wr_rdy |=> $stable(w_gray));

  // R9: occupancy stays within capacity
  p_level_in_range_r9: assert property (@(posedge wr_clk) disable iff (w_rst)
    wr_level <= CAP);

  // R5: a full count implies the ready flag is low
  p_full_blocks_r5: assert property (@(posedge wr_clk) disable iff (w_rst)
    (wr_level == CAP) |-> !wr_rdy);

  // R10: crossing pointers move one Gray step at a time
  p_wgray_step_r10: assert property (@(posedge wr_clk) disable iff (w_rst)
    $countones(w_gray ^ $past(w_gray)) <= 1);
  p_rgray_step_r10: assert property (@(posedge rd_clk) disable iff (r_rst)
    $countones(r_pop_gray ^ $past(r_pop_gray)) <= 1);

  // R2: without a full read request the output word and flag hold
  p_hold_output_r2: assert property (@(posedge rd_clk) disable iff (r_rst)
    (rd_rdy && !(rd_en_a && rd_en_b && rd_oe)) |=> (rd_rdy && $stable(rd_data)));

  // R3: output-ready only rises on a load into the output stage
  p_rise_on_load_r3: assert property (@(posedge rd_clk) disable iff (r_rst)
    $rose(rd_rdy) |-> $past(r_load));

  // R4: output-ready only falls after a consuming read
  p_fall_on_take_r4: assert property (@(posedge rd_clk) disable iff (r_rst)
    $fell(rd_rdy) |-> $past(r_take));
endmodule

bind xff_top xff_checks #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_checks (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .w_rst(w_rst), .r_rst(r_rst),
  .wr_rdy(wr_rdy), .wr_level(wr_level), .w_gray(w_gray), .r_pop_gray(r_pop_gray),
  .rd_rdy(rd_rdy), .rd_data(rd_data), .rd_en_a(rd_en_a), .rd_en_b(rd_en_b),
  .rd_oe(rd_oe), .r_load(r_load), .r_take(r_take));

// File: tb/test_xff_top.sv
module test_xff_top;
  localparam int WCLK_PERIOD = 10;
  localparam int RCLK_PERIOD = 12;
  localparam int CAP = 1025;

  logic wclk, rclk, rst_n;
  logic wr_en_a, wr_en_b, rd_en_a, rd_en_b, rd_oe;
  logic [17:0] wr_data, rd_data;
  logic [10:0] wr_level;
  logic wr_rdy, rd_rdy, rd_vld;

  xff_top i_xff_top (
    .wr_clk(wclk), .wr_en_a(wr_en_a), .wr_en_b(wr_en_b), .wr_data(wr_data),
    .wr_rdy(wr_rdy), .wr_level(wr_level), .rd_clk(rclk), .rd_en_a(rd_en_a),
    .rd_en_b(rd_en_b), .rd_oe(rd_oe), .rd_data(rd_data), .rd_rdy(rd_rdy),
    .rd_vld(rd_vld), .rst_n(rst_n));

  // Write edges at odd times, read edges at even times: never together.
  initial begin wclk = 0; forever #(WCLK_PERIOD/2) wclk = ~wclk; end
  initial begin rclk = 0; #2; forever #(RCLK_PERIOD/2) rclk = ~rclk; end

  int wcnt = 0, rcnt = 0;
  always @(posedge wclk) wcnt++;
  always @(posedge rclk) rcnt++;

  int nchecks = 0, nfails = 0;
  logic [17:0] sb[$];
  int accepted = 0, reads_done = 0, rd_wmark = 0;
  int mode = 0;          // 0 idle, 1 read always, 2 alternate, 3 oe low, 4 one read, 5 one enable
  bit mon_on = 0, seen = 0, rd_pending = 0, tog = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchecks++;
    if (!ok) begin
      nfails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchecks, nfails);
    $finish;
  endtask

  task automatic wait_w(input int target);
    wait (wcnt >= target); #2;
  endtask

  task automatic wait_r(input int target);
    wait (rcnt >= target); #2;
  endtask

  // Driver: one write attempt; the expected word enters the scoreboard if accepted.
  task automatic wr_word(input logic [17:0] d, input bit a, input bit b, output int mark);
    bit acc;
    wr_data = d; wr_en_a = a; wr_en_b = b;
    acc = a && b && wr_rdy;
    @(posedge wclk);
    mark = rcnt;
    if (acc) begin sb.push_back(d); accepted++; end
    #2; wr_en_a = 0; wr_en_b = 0;
  endtask

  // Monitor: compares each word shown at the output with the scoreboard head.
  initial begin
    bit consumed, re, oe_n;
    logic [17:0] exp;
    forever begin
      @(posedge rclk);
      consumed = 0;
      if (rd_pending) begin
        rd_pending = 0; rd_wmark = wcnt; reads_done++; consumed = 1; seen = 0;
      end
      #2;
      if (mon_on) begin
        chk(rd_vld == (rd_rdy && rd_oe), "R8 valid", rd_vld, rd_rdy && rd_oe);
        if (consumed && sb.size() == 0) chk(!rd_rdy, "R4 ready after last read", rd_rdy, 0);
        if (rd_rdy && !seen) begin
          if (sb.size() == 0) chk(0, "R10 unexpected word", rd_data, 0);
          else begin
            exp = sb.pop_front();
            chk(rd_data == exp, "R10 order", rd_data, exp);
          end
          seen = 1;
        end
        tog = !tog;
        re = (mode == 1) || (mode == 2 && tog) || (mode == 3) || (mode == 4);
        oe_n = (mode != 3);
        rd_en_a = re || (mode == 5);
        rd_en_b = re;
        rd_oe = oe_n;
        rd_pending = re && oe_n && rd_rdy;
        if (mode == 4 && rd_pending) mode = 0;
      end
    end
  end

  initial begin
    #(WCLK_PERIOD * 100000);
    nchecks++; nfails++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    int m, prior;
    rst_n = 0; wr_en_a = 0; wr_en_b = 0; wr_data = 0;
    rd_en_a = 0; rd_en_b = 0; rd_oe = 1;
    wait_w(6); wait_r(6);
    chk(wr_rdy == 0, "R7 wr_rdy in reset", wr_rdy, 0);
    chk(rd_rdy == 0, "R7 rd_rdy in reset", rd_rdy, 0);
    chk(rd_vld == 0, "R8 rd_vld in reset", rd_vld, 0);
    chk(wr_level == 0, "R9 level in reset", wr_level, 0);
    rst_n = 1; m = wcnt;
    wait_w(m + 1); chk(wr_rdy == 0, "R7 wr_rdy one edge after release", wr_rdy, 0);
    wait_w(m + 2); chk(wr_rdy == 1, "R7 wr_rdy two edges after release", wr_rdy, 1);
    wait_r(rcnt + 2);
    mon_on = 1; mode = 0;

    // R3: fall-through with read enables low
    wr_word(18'h2A5C1, 1, 1, m);
    wait_r(m + 2); chk(rd_rdy == 0, "R3 not ready after two edges", rd_rdy, 0);
    wait_r(m + 3);
    chk(rd_rdy == 1, "R3 ready at third edge", rd_rdy, 1);
    chk(rd_data == 18'h2A5C1, "R3 word at third edge", rd_data, 18'h2A5C1);
    chk(wr_level == 1, "R9 level after one write", wr_level, 1);

    // R8 and R2: no consumption with oe low or one enable low
    mode = 3; wait_r(rcnt + 4);
    chk(rd_vld == 0, "R8 oe low hides word", rd_vld, 0);
    chk(rd_rdy == 1, "R2 oe low does not read", rd_rdy, 1);
    mode = 5; wait_r(rcnt + 4);
    chk(rd_rdy == 1, "R2 single enable does not read", rd_rdy, 1);
    mode = 0; wait_r(rcnt + 2);
    chk(rd_vld == 1 && rd_data == 18'h2A5C1, "R2 word kept", rd_data, 18'h2A5C1);

    // R1: single write enable drops the word
    wr_word(18'h11111, 1, 0, m);
    wr_word(18'h22222, 0, 1, m);
    chk(wr_level == 1, "R1 level unchanged", wr_level, 1);

    // Streams under two read patterns
    mode = 1;
    for (int i = 0; i < 40; i++) wr_word(18'(i * 7919 + 3), 1, 1, m);
    wait (sb.size() == 0); wait_r(rcnt + 3);
    chk(rd_rdy == 0, "R4 empty after stream", rd_rdy, 0);
    mode = 2;
    for (int i = 0; i < 30; i++) wr_word(18'h3FFFF - 18'(i * 4099), 1, 1, m);
    wait (sb.size() == 0); wait_r(rcnt + 3); wait_w(wcnt + 3);
    chk(wr_level == 11'(accepted - reads_done), "R9 level after drain", wr_level, accepted - reads_done);

    // R5: fill to capacity with reads off
    mode = 0; wait_r(rcnt + 2);
    for (int i = 0; i < CAP; i++) begin
      if (i == CAP - 1) chk(wr_rdy == 1, "R5 ready before last slot", wr_rdy, 1);
      wr_word(18'(i * 37 + 5), 1, 1, m);
    end
    chk(wr_rdy == 0, "R5 not ready when full", wr_rdy, 0);
    chk(wr_level == 11'(CAP), "R9 level at capacity", wr_level, CAP);
    wr_word(18'h0BEEF, 1, 1, m);
    chk(wr_level == 11'(CAP), "R5 extra write dropped", wr_level, CAP);

    // R6: one read, ready returns on the second write edge
    prior = reads_done; mode = 4;
    wait (reads_done == prior + 1);
    m = rd_wmark;
    wait_w(m + 1); chk(wr_rdy == 0, "R6 not ready one edge after read", wr_rdy, 0);
    wait_w(m + 2); chk(wr_rdy == 1, "R6 ready two edges after read", wr_rdy, 1);
    chk(wr_level == 11'(CAP - 1), "R9 level after one read", wr_level, CAP - 1);

    mode = 1;
    wait (sb.size() == 0); wait_r(rcnt + 3); wait_w(wcnt + 3);
    chk(rd_rdy == 0, "R4 empty after full drain", rd_rdy, 0);
    chk(wr_level == 0, "R9 level zero after drain", wr_level, 0);

    // R7: reset while holding data
    mode = 0;
    wr_word(18'h01234, 1, 1, m);
    wr_word(18'h05678, 1, 1, m);
    wait_r(rcnt + 5);
    chk(rd_rdy == 1, "R3 ready before reset", rd_rdy, 1);
    rst_n = 0;
    fork
      begin
        int wm; wm = wcnt;
        wait_w(wm + 1); chk(wr_rdy == 1, "R7 wr_rdy one edge into reset", wr_rdy, 1);
        wait_w(wm + 2); chk(wr_rdy == 0, "R7 wr_rdy two edges into reset", wr_rdy, 0);
      end
      begin
        int rm; rm = rcnt;
        wait_r(rm + 2); chk(rd_rdy == 1, "R7 rd_rdy two edges into reset", rd_rdy, 1);
        wait_r(rm + 3); chk(rd_rdy == 0, "R7 rd_rdy three edges into reset", rd_rdy, 0);
      end
    join
    wait_w(wcnt + 4); wait_r(rcnt + 4);
    sb.delete(); seen = 0; accepted = 0; reads_done = 0;
    rst_n = 1;
    wait_w(wcnt + 3); wait_r(rcnt + 3);
    chk(wr_level == 0, "R7 empty after reset", wr_level, 0);
    chk(rd_rdy == 0, "R7 no word after reset", rd_rdy, 0);
    wr_word(18'h2F00D, 1, 1, m);
    wait_r(m + 3);
    chk(rd_rdy == 1 && rd_data == 18'h2F00D, "R3 fall-through after reset", rd_data, 18'h2F00D);
    wait_r(rcnt + 2);
    summary();
  end
endmodule